// File: doc/BRIEF.md
# Dual-Strobe Up/Down Presettable Counter

A 4-bit counter that counts up on one strobe input and down on another. Whichever strobe is not in use rests high, and the other is pulsed low and released. The counter steps on the release, which is a low-to-high transition. A parameter selects decade operation (values 0 to 9) or plain binary operation (values 0 to 15).

A parallel preset is taken while an active-low load is held, and an active-high clear empties the counter at once. Two active-low outputs signal the terminal counts. They are shaped so that they can feed the up and down strobes of a following stage directly, which lets several stages form a wider counter.

Both strobes are brought into the system clock domain through a synchronizer chain and then edge-detected, so the whole block runs on one clock.

Top module: `dual_strobe_counter`

## Requirements
- R1: While `clr` is 1, `count` is 0 at once, without waiting for a clock edge. This overrides load and counting.
- R2: With `clr` at 0, a clock edge that samples `loadN` at 0 puts `presetVal` into `count`. Load overrides any count step on that edge.
- R3: A 0-to-1 transition on `upIn` adds one to `count`. The change appears on the third rising clock edge after the transition.
- R4: A 0-to-1 transition on `downIn` subtracts one from `count`, with the same three-edge latency.
- R5: In decade mode (`DECADE`=1), counting up from 9 gives 0 and counting down from 0 gives 9.
- R6: In binary mode (`DECADE`=0), counting up from 15 gives 0 and counting down from 0 gives 15.
- R7: `carryN` is 0 exactly while `count` equals the top value (9 or 15) and `upIn`, as sampled two rising edges earlier, was 0. Otherwise it is 1.
- R8: `borrowN` is 0 exactly while `count` is 0 and `downIn`, as sampled two rising edges earlier, was 0. Otherwise it is 1.
- R9: If the synchronized up and down transitions land on the same clock edge, `count` does not change.
- R10: In decade mode, a preset from 10 to 15 is kept. From such a value, an up step gives 0 and a down step subtracts one.
- R11: After `rstN` is asserted, `count` is 0 and both `carryN` and `borrowN` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| upIn | input | 1 | Up-count strobe; steps on its rising edge |
| downIn | input | 1 | Down-count strobe; steps on its rising edge |
| loadN | input | 1 | Parallel load, active low, sampled on the clock |
| clr | input | 1 | Asynchronous clear, active high |
| presetVal | input | 4 | Value taken on load |
| count | output | 4 | Counter value |
| carryN | output | 1 | Terminal-count-up indication, active low |
| borrowN | output | 1 | Terminal-count-down indication, active low |

## Verification
A strobe transition moves `count` on the third rising edge after it: two edges in the synchronizer and one in the counter register. The same transition moves `carryN` and `borrowN` on the second edge. A load lands on the first edge, and a clear takes effect immediately.

The bench drives inputs 2 ns after a rising edge. It keeps a reference model that updates on every rising edge from a history queue of the sampled strobes, and it compares `count`, `carryN` and `borrowN` for a decade instance and a binary instance at every falling edge. Directed checks then compare the value reached at the end of each sequence with constants worked out from the requirements.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef struct packed {
    logic inc;
    logic dec;
    logic load;
  } stepCmdT;
endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic prevLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain     <= '1;
      prevLevel <= 1'b1;
    end else begin
      chain     <= {chain[STAGES-2:0], rawIn};
      prevLevel <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prevLevel;
endmodule

// File: rtl/dsc_ctrl.sv
module dsc_ctrl
  import dsc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    upIn,
  input  logic    downIn,
  input  logic    loadN,
  output stepCmdT cmd,
  output logic    upLvl,
  output logic    downLvl
);
  logic [1:0] rawPair;
  logic [1:0] lvlPair;
  logic [1:0] risePair;

  assign rawPair = {downIn, upIn};

  for (genvar g = 0; g < 2; g++) begin : g_chan
    dsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rstN  (rstN),
      .rawIn (rawPair[g]),
      .level (lvlPair[g]),
      .rise  (risePair[g])
    );
  end

  assign upLvl   = lvlPair[0];
  assign downLvl = lvlPair[1];

  always_comb begin
    cmd.load = ~loadN;
    // a simultaneous pair cancels out
    cmd.inc  = risePair[0] & ~risePair[1];
    cmd.dec  = risePair[1] & ~risePair[0];
  end
endmodule

// File: rtl/dsc_dpath.sv
module dsc_dpath
  import dsc_pkg::*;
#(
  parameter int W      = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic [W-1:0] presetVal,
  input  stepCmdT      cmd,
  input  logic         upLvl,
  input  logic         downLvl,
  output logic [W-1:0] count,
  output logic         carryN,
  output logic         borrowN
);
  localparam logic [W-1:0] TOPV = DECADE ? W'(9) : {W{1'b1}};

  logic [W-1:0] cntQ;
  logic [W-1:0] cntNext;

  always_comb begin
    cntNext = cntQ;
    if (cmd.load)
      cntNext = presetVal;
    else if (cmd.inc)
      cntNext = (cntQ >= TOPV) ? '0 : cntQ + W'(1);
    else if (cmd.dec)
      cntNext = (cntQ == '0) ? TOPV : cntQ - W'(1);
  end

  always_ff @(posedge clk or negedge rstN or posedge clr) begin
    if (!rstN || clr) cntQ <= '0;
    else              cntQ <= cntNext;
  end

  assign count   = cntQ;
  assign carryN  = ~((cntQ == TOPV) & ~upLvl);
  assign borrowN = ~((cntQ == '0) & ~downLvl);
endmodule

// File: rtl/dual_strobe_counter.sv
module dual_strobe_counter
  import dsc_pkg::*;
#(
  parameter int W           = 4,
  parameter bit DECADE      = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         upIn,
  input  logic         downIn,
  input  logic         loadN,
  input  logic         clr,
  input  logic [W-1:0] presetVal,
  output logic [W-1:0] count,
  output logic         carryN,
  output logic         borrowN
);
  stepCmdT cmd;
  logic    upLvl;
  logic    downLvl;

  dsc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .upIn    (upIn),
    .downIn  (downIn),
    .loadN   (loadN),
    .cmd     (cmd),
    .upLvl   (upLvl),
    .downLvl (downLvl)
  );

  dsc_dpath #(.W(W), .DECADE(DECADE)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .clr       (clr),
    .presetVal (presetVal),
    .cmd       (cmd),
    .upLvl     (upLvl),
    .downLvl   (downLvl),
    .count     (count),
    .carryN    (carryN),
    .borrowN   (borrowN)
  );
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker
  import dsc_pkg::*;
#(
  parameter int W      = 4,
  parameter bit DECADE = 1'b1
) (
  input logic         clk,
  input logic         rstN,
  input logic         clr,
  input logic         loadN,
  input logic [W-1:0] presetVal,
  input logic [W-1:0] count,
  input logic         carryN,
  input logic         borrowN,
  input stepCmdT      cmd
);
  localparam logic [W-1:0] TOPV = DECADE ? W'(9) : {W{1'b1}};

  a_r1_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    clr |-> count == '0);

  a_r2_load_takes: assert property (@(posedge clk) disable iff (!rstN)
    (!loadN && !clr) |=> (clr || count == $past(presetVal)));

  a_r7_carry_at_top: assert property (@(posedge clk) disable iff (!rstN)
    !carryN |-> count == TOPV);

  a_r8_borrow_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    !borrowN |-> count == '0);

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (loadN && !clr && !cmd.inc && !cmd.dec) |=> (clr || $stable(count)));

  a_r9_one_direction: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.inc && cmd.dec));
endmodule

bind dual_strobe_counter dsc_checker #(.W(W), .DECADE(DECADE)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .clr       (clr),
  .loadN     (loadN),
  .presetVal (presetVal),
  .count     (count),
  .carryN    (carryN),
  .borrowN   (borrowN),
  .cmd       (cmd)
);

// File: tb/sim_dual_strobe_counter.sv
module sim_dual_strobe_counter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic upIn = 1'b1, downIn = 1'b1, loadN = 1'b1, clr = 1'b0;
  logic [3:0] presetVal = '0;
  logic [3:0] cnt0, cnt1;
  logic cy0, cy1, bw0, bw1;

  int total = 0;
  int bad = 0;
  string tag = "R11";
  bit running = 1'b0;

  always #5 clk = ~clk;

  dual_strobe_counter #(.W(4), .DECADE(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .upIn(upIn), .downIn(downIn), .loadN(loadN),
    .clr(clr), .presetVal(presetVal), .count(cnt0), .carryN(cy0), .borrowN(bw0));

  dual_strobe_counter #(.W(4), .DECADE(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .upIn(upIn), .downIn(downIn), .loadN(loadN),
    .clr(clr), .presetVal(presetVal), .count(cnt1), .carryN(cy1), .borrowN(bw1));

  // reference model: index 0 decade, index 1 binary
  int mCnt[2];
  int topv[2] = '{9, 15};
  bit upQ[$];
  bit dnQ[$];

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  always @(posedge clr) begin
    mCnt[0] = 0;
    mCnt[1] = 0;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      upQ = '{1, 1, 1, 1};
      dnQ = '{1, 1, 1, 1};
      mCnt[0] = 0;
      mCnt[1] = 0;
    end else begin
      bit upStep, dnStep;
      upQ.push_front(upIn);
      dnQ.push_front(downIn);
      void'(upQ.pop_back());
      void'(dnQ.pop_back());
      upStep = upQ[2] && !upQ[3];
      dnStep = dnQ[2] && !dnQ[3];
      for (int i = 0; i < 2; i++) begin
        if (clr) mCnt[i] = 0;
        else if (!loadN) mCnt[i] = presetVal;
        else if (upStep && !dnStep) mCnt[i] = (mCnt[i] >= topv[i]) ? 0 : mCnt[i] + 1;
        else if (dnStep && !upStep) mCnt[i] = (mCnt[i] == 0) ? topv[i] : mCnt[i] - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (running) begin
      chk({tag, " count dec"}, cnt0, mCnt[0]);
      chk({tag, " count bin"}, cnt1, mCnt[1]);
      chk("R7 carryN dec", cy0, !(mCnt[0] == 9 && upQ[1] == 0));
      chk("R7 carryN bin", cy1, !(mCnt[1] == 15 && upQ[1] == 0));
      chk("R8 borrowN dec", bw0, !(mCnt[0] == 0 && dnQ[1] == 0));
      chk("R8 borrowN bin", bw1, !(mCnt[1] == 0 && dnQ[1] == 0));
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulseUp(int n);
    for (int k = 0; k < n; k++) begin
      upIn = 1'b0; step(3);
      upIn = 1'b1; step(4);
    end
  endtask

  task automatic pulseDown(int n);
    for (int k = 0; k < n; k++) begin
      downIn = 1'b0; step(3);
      downIn = 1'b1; step(4);
    end
  endtask

  task automatic loadVal(int v);
    presetVal = 4'(v);
    loadN = 1'b0; step(1);
    loadN = 1'b1; step(1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    // R11 reset state
    chk("R11 count", cnt0, 0);
    chk("R11 carryN", cy0, 1);
    chk("R11 borrowN", bw0, 1);
    rstN = 1'b1;
    step(2);
    running = 1'b1;

    // R2 load, then R1 clear overriding a held load
    tag = "R2"; loadVal(5);
    chk("R2 load 5", cnt0, 5);
    tag = "R1";
    clr = 1'b1; #1;
    chk("R1 async clear", cnt0, 0);
    presetVal = 4'd3; loadN = 1'b0;
    step(2);
    chk("R1 clear over load", cnt1, 0);
    loadN = 1'b1; clr = 1'b0; step(2);

    // R3 latency: unchanged after two edges, stepped at the third
    tag = "R3"; loadVal(7);
    upIn = 1'b0; step(3);
    upIn = 1'b1; step(2);
    chk("R3 not yet", cnt0, 7);
    step(1);
    chk("R3 stepped", cnt0, 8);
    step(3);
    // R5 up through 9 with carry, then 0,1,2
    tag = "R5"; pulseUp(1);
    chk("R5 at nine", cnt0, 9);
    upIn = 1'b0; step(3);
    chk("R7 carry low at 9", cy0, 0);
    upIn = 1'b1; step(4);
    pulseUp(2);
    chk("R5 up wrap", cnt0, 2);
    // R4 and R5 down through 0 with borrow, then 9,8,7
    tag = "R4"; pulseDown(2);
    chk("R4 down to 0", cnt0, 0);
    downIn = 1'b0; step(3);
    chk("R8 borrow low at 0", bw0, 0);
    downIn = 1'b1; step(4);
    tag = "R5"; pulseDown(2);
    chk("R5 down wrap", cnt0, 7);

    // R6 binary run from 13; same stimulus puts decade into R10 range
    tag = "R6"; loadVal(13);
    chk("R10 preset 13 kept", cnt0, 13);
    pulseUp(2);
    chk("R6 at fifteen", cnt1, 15);
    chk("R10 up from 13 to 0", cnt0, 1);
    pulseUp(3);
    chk("R6 up wrap", cnt1, 2);
    pulseDown(5);
    chk("R6 down wrap", cnt1, 13);
    tag = "R10"; loadVal(12);
    pulseDown(1);
    chk("R10 down from 12", cnt0, 11);

    // R9 simultaneous edges cancel
    tag = "R9"; loadVal(4);
    upIn = 1'b0; downIn = 1'b0; step(3);
    upIn = 1'b1; downIn = 1'b1; step(4);
    chk("R9 both edges hold", cnt0, 4);
    chk("R9 both edges hold bin", cnt1, 4);

    running = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule